// File: doc/BRIEF.md
# Pin-Multiplexed Operand Loader and Result Presenter

This block lets an arithmetic core with two 8-bit operands and a 16-bit result be driven through a narrow pin budget. A single 8-bit data bus loads both operands one after the other. An address bit selects the operand being loaded. The same address bit picks which half of the result appears on an 8-bit output. The arithmetic core sits outside this block. The block drives the core's operand inputs and takes back its 16-bit result and its error flags.

Each operand cell acts like a level-sensitive latch. While the clock is high and the cell's address is selected, the operand seen by the core follows the data bus. The cell keeps the bus value from the falling clock edge onward. Because the core always sees the open-or-held operands, its result tracks the inputs while a cell is open.

The output has two modes. In the direct mode it shows the core's live result and flags. In the snapshot mode it shows a registered copy of result and flags. That copy is taken on the first rising edge after the falling edge that closes the second operand. It is then held while the next operand pair is loaded, so loading and readout can overlap.

Top module: `mulx_port_frontend`

## Requirements
- R1: A synchronous reset clears both held operands (at the falling clock edge) and the result snapshot and its flags (at the rising clock edge), so after reset `op_a`, `op_b`, and the snapshot view of `dout`/`err_out` all read zero while the clock is low.
- R2: With `addr`=0 the operand A cell takes `din` at the falling clock edge. With `addr`=1 the operand B cell does so. A cell that is not addressed keeps its held value.
- R3: While `clk` is high and a cell is addressed, its operand output (`op_a` for `addr`=0, `op_b` for `addr`=1) equals `din` combinationally. Otherwise it shows the held value.
- R4: With `snap_mode`=0, `dout` shows `core_res[7:0]` when `addr`=0 and `core_res[15:8]` when `addr`=1, and `err_out` equals `core_err`.
- R5: With `snap_mode`=1, the full `core_res` is captured on the first rising clock edge after a falling edge where `addr` was 1. `dout` then shows the low half for `addr`=0 and the high half for `addr`=1.
- R6: Without a new falling edge at `addr`=1, the snapshot stays unchanged while operand A is reloaded and the core result moves, so the captured result can be read during the next load.
- R7: With `snap_mode`=1, `err_out` shows the `core_err` value captured together with the result snapshot, not the live flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; high phase opens the addressed operand cell |
| rst | input | 1 | Synchronous active-high reset |
| din | input | DATA_W | Shared operand data bus |
| addr | input | 1 | 0 selects operand A / low result half, 1 selects operand B / high half |
| snap_mode | input | 1 | 0 = direct result view, 1 = registered snapshot |
| op_a | output | DATA_W | Operand A to the arithmetic core |
| op_b | output | DATA_W | Operand B to the arithmetic core |
| core_res | input | 2*DATA_W | Result from the arithmetic core |
| core_err | input | ERR_W | Error flags from the arithmetic core |
| dout | output | DATA_W | Selected half of the result |
| err_out | output | ERR_W | Error flags, live or snapshot |

## Verification
A wrong held operand shows on `op_a`/`op_b` in the low phase just after the falling edge that should have loaded it. It also shows on the direct-mode `dout` one core delay later. A snapshot taken on the wrong edge, or one that is not held, shows in snapshot mode as soon as operand A is reloaded: the live core result then differs from the captured one. The stimulus makes sure the reloaded value differs from the captured operand. A wrong half selection or wrong flag source shows within the same low phase that `addr` or `snap_mode` is flipped.

// File: rtl/mulx_port_pkg.sv
package mulx_port_pkg;

  typedef enum logic {
    VIEW_LIVE = 1'b0,
    VIEW_SNAP = 1'b1
  } view_mode_e;

  localparam logic SEL_A = 1'b0;
  localparam logic SEL_B = 1'b1;

endpackage

// File: rtl/mulx_operand_cell.sv
module mulx_operand_cell #(
  parameter int  DATA_W = 8,
  parameter logic SEL   = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] held,
  output logic [DATA_W-1:0] view
);

  logic              picked;
  logic [DATA_W-1:0] held_q;

  assign picked = (addr == SEL);

  // value closes on the falling edge of the open phase
  always_ff @(negedge clk) begin
    if (rst) begin
      held_q <= '0;
    end else if (picked) begin
      held_q <= din;
    end
  end

  // transparent path while the clock is high and the cell is addressed
  assign view = (clk && picked) ? din : held_q;
  assign held = held_q;

endmodule

// File: rtl/mulx_result_snapshot.sv
module mulx_result_snapshot #(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 2,
  localparam int RES_W = 2 * DATA_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             addr,
  input  logic [RES_W-1:0] core_res,
  input  logic [ERR_W-1:0] core_err,
  output logic             pend,
  output logic [RES_W-1:0] snap_res,
  output logic [ERR_W-1:0] snap_err
);

  logic             pend_q;
  logic [RES_W-1:0] res_q;
  logic [ERR_W-1:0] err_q;

  // flag that the last operand cell has just closed
  always_ff @(negedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= (addr == mulx_port_pkg::SEL_B);
    end
  end

  // capture the settled core output on the following rising edge
  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      err_q <= '0;
    end else if (pend_q) begin
      res_q <= core_res;
      err_q <= core_err;
    end
  end

  assign pend     = pend_q;
  assign snap_res = res_q;
  assign snap_err = err_q;

endmodule

// File: rtl/mulx_half_select.sv
module mulx_half_select #(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 2,
  localparam int RES_W = 2 * DATA_W
) (
  input  mulx_port_pkg::view_mode_e mode,
  input  logic                      addr,
  input  logic [RES_W-1:0]          live_res,
  input  logic [ERR_W-1:0]          live_err,
  input  logic [RES_W-1:0]          snap_res,
  input  logic [ERR_W-1:0]          snap_err,
  output logic [DATA_W-1:0]         dout,
  output logic [ERR_W-1:0]          err_out
);

  logic [RES_W-1:0] chosen;

  always_comb begin
    if (mode == mulx_port_pkg::VIEW_SNAP) begin
      chosen  = snap_res;
      err_out = snap_err;
    end else begin
      chosen  = live_res;
      err_out = live_err;
    end
    if (addr == mulx_port_pkg::SEL_B) begin
      dout = chosen[RES_W-1:DATA_W];
    end else begin
      dout = chosen[DATA_W-1:0];
    end
  end

endmodule

// File: rtl/mulx_port_frontend.sv
module mulx_port_frontend #(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 2,
  localparam int RES_W = 2 * DATA_W,
  localparam int N_OPS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  logic              addr,
  input  logic              snap_mode,
  output logic [DATA_W-1:0] op_a,
  output logic [DATA_W-1:0] op_b,
  input  logic [RES_W-1:0]  core_res,
  input  logic [ERR_W-1:0]  core_err,
  output logic [DATA_W-1:0] dout,
  output logic [ERR_W-1:0]  err_out
);

  logic [DATA_W-1:0] held_w [N_OPS];
  logic [DATA_W-1:0] view_w [N_OPS];
  logic [DATA_W-1:0] held_a;
  logic [DATA_W-1:0] held_b;
  logic              cap_pend;
  logic [RES_W-1:0]  snap_res;
  logic [ERR_W-1:0]  snap_err;
  mulx_port_pkg::view_mode_e mode_w;

  for (genvar g = 0; g < N_OPS; g++) begin : g_cell
    mulx_operand_cell #(
      .DATA_W(DATA_W),
      .SEL   (1'(g))
    ) u_cell (
      .clk (clk),
      .rst (rst),
      .addr(addr),
      .din (din),
      .held(held_w[g]),
      .view(view_w[g])
    );
  end

  assign op_a   = view_w[0];
  assign op_b   = view_w[1];
  assign held_a = held_w[0];
  assign held_b = held_w[1];

  mulx_result_snapshot #(
    .DATA_W(DATA_W),
    .ERR_W (ERR_W)
  ) u_snap (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .core_res(core_res),
    .core_err(core_err),
    .pend    (cap_pend),
    .snap_res(snap_res),
    .snap_err(snap_err)
  );

  assign mode_w = mulx_port_pkg::view_mode_e'(snap_mode);

  mulx_half_select #(
    .DATA_W(DATA_W),
    .ERR_W (ERR_W)
  ) u_sel (
    .mode    (mode_w),
    .addr    (addr),
    .live_res(core_res),
    .live_err(core_err),
    .snap_res(snap_res),
    .snap_err(snap_err),
    .dout    (dout),
    .err_out (err_out)
  );

endmodule

// File: rtl/mulx_port_frontend_chk.sv
module mulx_port_frontend_chk #(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 2,
  localparam int RES_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] din,
  input logic              addr,
  input logic [DATA_W-1:0] held_a,
  input logic [DATA_W-1:0] held_b,
  input logic [RES_W-1:0]  core_res,
  input logic [ERR_W-1:0]  core_err,
  input logic              pend,
  input logic [RES_W-1:0]  snap_res,
  input logic [ERR_W-1:0]  snap_err
);

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (snap_res == '0 && snap_err == '0));

  assert_load_a_R2: assert property (@(negedge clk) disable iff (rst)
    !addr |=> (held_a == $past(din)));

  assert_keep_a_R2: assert property (@(negedge clk) disable iff (rst)
    addr |=> $stable(held_a));

  assert_keep_b_R2: assert property (@(negedge clk) disable iff (rst)
    !addr |=> $stable(held_b));

  assert_capture_R5: assert property (@(posedge clk) disable iff (rst)
    pend |=> (snap_res == $past(core_res) && snap_err == $past(core_err)));

  assert_snap_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !pend |=> ($stable(snap_res) && $stable(snap_err)));

endmodule

bind mulx_port_frontend mulx_port_frontend_chk #(
  .DATA_W(DATA_W),
  .ERR_W (ERR_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .din     (din),
  .addr    (addr),
  .held_a  (held_a),
  .held_b  (held_b),
  .core_res(core_res),
  .core_err(core_err),
  .pend    (cap_pend),
  .snap_res(snap_res),
  .snap_err(snap_err)
);

// File: tb/test_mulx_port_frontend.sv
`timescale 1ns/1ps
module test_mulx_port_frontend;

  localparam int DATA_W = 8;
  localparam int ERR_W  = 2;
  localparam int RES_W  = 2 * DATA_W;
  localparam int N_VEC  = 8;

  // {a, b, expected product}
  localparam logic [31:0] VEC [N_VEC] = '{
    {8'h03, 8'h05, 16'h000F},
    {8'hFF, 8'hFF, 16'hFE01},
    {8'h00, 8'h80, 16'h0000},
    {8'h12, 8'h34, 16'h03A8},
    {8'h80, 8'h02, 16'h0100},
    {8'h01, 8'hFF, 16'h00FF},
    {8'hF0, 8'h10, 16'h0F00},
    {8'hAA, 8'h55, 16'h3872}
  };

  logic              clk = 1'b0;
  logic              rst;
  logic [DATA_W-1:0] din;
  logic              addr;
  logic              snap_mode;
  logic [DATA_W-1:0] op_a;
  logic [DATA_W-1:0] op_b;
  logic [RES_W-1:0]  core_res;
  logic [ERR_W-1:0]  core_err;
  logic [DATA_W-1:0] dout;
  logic [ERR_W-1:0]  err_out;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  // behavioural core with a propagation delay
  assign #1 core_res = {8'h00, op_a} * {8'h00, op_b};
  assign #1 core_err = {op_a[7] & op_b[7], (op_b == 8'h00)};

  mulx_port_frontend #(
    .DATA_W(DATA_W),
    .ERR_W (ERR_W)
  ) i_mulx_port_frontend (
    .clk      (clk),
    .rst      (rst),
    .din      (din),
    .addr     (addr),
    .snap_mode(snap_mode),
    .op_a     (op_a),
    .op_b     (op_b),
    .core_res (core_res),
    .core_err (core_err),
    .dout     (dout),
    .err_out  (err_out)
  );

  function automatic logic [ERR_W-1:0] exp_err(input logic [7:0] a, input logic [7:0] b);
    return {a[7] & b[7], (b == 8'h00)};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_pair(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    #1 addr = 1'b0; din = a;
    @(negedge clk);
    #1 addr = 1'b1; din = b;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; din = 8'h5A; addr = 1'b0; snap_mode = 1'b1;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    #1;
    chk("R1 op_a after reset", 16'(op_a), 16'h0);
    chk("R1 op_b after reset", 16'(op_b), 16'h0);
    chk("R1 snapshot low", 16'(dout), 16'h0);
    chk("R1 snapshot err", 16'(err_out), 16'h0);
    addr = 1'b1; #1;
    chk("R1 snapshot high", 16'(dout), 16'h0);

    // table walk
    for (int i = 0; i < N_VEC; i++) begin
      logic [7:0]  va;
      logic [7:0]  vb;
      logic [15:0] vp;
      logic [7:0]  junk;
      va = VEC[i][31:24]; vb = VEC[i][23:16]; vp = VEC[i][15:0];
      junk = ~va;
      load_pair(va, vb);
      #2 snap_mode = 1'b0;
      #0;
      chk("R2 op_a held", 16'(op_a), 16'(va));
      chk("R2 op_b held", 16'(op_b), 16'(vb));
      chk("R4 live high", 16'(dout), 16'(vp[15:8]));
      chk("R4 live err", 16'(err_out), 16'(exp_err(va, vb)));
      #1 addr = 1'b0;
      #0;
      chk("R4 live low", 16'(dout), 16'(vp[7:0]));
      din = junk;
      @(posedge clk);
      #1 snap_mode = 1'b1;
      #1;
      chk("R3 op_a transparent", 16'(op_a), 16'(junk));
      chk("R6 snapshot low held during reload", 16'(dout), 16'(vp[7:0]));
      chk("R7 snapshot err", 16'(err_out), 16'(exp_err(va, vb)));
      @(negedge clk);
      #1 addr = 1'b1;
      #1;
      chk("R5 snapshot high", 16'(dout), 16'(vp[15:8]));
    end

    // R2 / R3 directed: unaddressed cell keeps value, addressed one follows
    load_pair(8'h3C, 8'hC3);
    #1 din = 8'h11;
    @(posedge clk);
    #2;
    chk("R3 op_b follows din while high", 16'(op_b), 16'h0011);
    chk("R2 op_a unaffected by addr 1", 16'(op_a), 16'h003C);
    @(negedge clk);
    #1 din = 8'h99;
    #1;
    chk("R2 op_b closed at falling edge", 16'(op_b), 16'h0011);
    chk("R2 op_a still held", 16'(op_a), 16'h003C);

    // R6 directed: the snapshot is untouched while live result moves
    load_pair(8'h10, 8'h10);
    #1 addr = 1'b0; din = 8'h20;
    @(negedge clk);
    #1 snap_mode = 1'b0;
    #1;
    chk("R4 live low after reload", 16'(dout), 16'h0000);
    snap_mode = 1'b1;
    #1;
    chk("R6 snapshot low unchanged", 16'(dout), 16'h0000);
    addr = 1'b1;
    #1;
    chk("R6 snapshot high unchanged", 16'(dout), 16'h0001);

    // R1 directed: reset in the middle of operation
    load_pair(8'h77, 8'h99);
    @(posedge clk);
    @(negedge clk);
    #1 rst = 1'b1;
    @(negedge clk);
    #1 rst = 1'b0;
    #1;
    chk("R1 op_a after mid reset", 16'(op_a), 16'h0);
    chk("R1 op_b after mid reset", 16'(op_b), 16'h0);
    chk("R1 snapshot after mid reset", 16'(dout), 16'h0);

    finish_run();
  end

endmodule